// File: doc/BRIEF.md
# EEPROM Page Write Collector and Commit Engine

This block gathers the data bytes of one write transaction into a page-wide holding latch. When the bus front end reports a valid end of transfer, the block writes those bytes into an on-chip byte array in a single timed write cycle. A transaction opens with a start pulse and a byte address. The upper address bits choose the row (the page). The lower bits give the first in-page offset. Each byte strobe stores one byte at the current offset. The offset then advances and wraps inside the row, so it never carries into the row bits.

A commit pulse closes the transaction. The write runs only when at least one byte was loaded and the write-protect input was low when the transaction opened. In that case the engine holds `busy` high for a fixed number of cycles and ignores all other requests. On the last busy edge it updates only the loaded locations and moves the next-address counter one past the last byte stored. A commit that is empty or protected does nothing. A read port gives combinational access to the array.

Top module: `eeprom_page_commit`

## Requirements
- R1: After synchronous reset, `busy` is 0, `next_addr` is 0 and every byte of the array reads 0.
- R2: A `txn_start` pulse while not busy opens a transaction and replaces any transaction already open. Bits [ADDR_W-1:OFS_W] of `txn_addr` select the row and bits [OFS_W-1:0] set the in-page pointer, where OFS_W = log2(PAGE_BYTES). The pulse clears the loaded-byte mask and latches `wr_protect`.
- R3: While a transaction is open, each `byte_stb` that does not share its cycle with `txn_start` stores `byte_data` at the current in-page pointer, marks that offset as loaded and increments the pointer.
- R4: The pointer wraps from PAGE_BYTES-1 to 0 inside the same row. A later byte at an offset already loaded replaces the earlier one, and the row never changes.
- R5: A `commit` in an open transaction with at least one loaded byte and `wr_protect` latched low raises `busy` on the next cycle. `busy` stays high for exactly TW_CYCLES cycles.
- R6: The array changes only at the clock edge where `busy` falls. Only the offsets loaded in that transaction are written, and every other byte, including the rest of the row, keeps its value.
- R7: When the write completes, `next_addr` becomes ({row, offset of the last byte stored} + 1) modulo 2^ADDR_W. At any other time `next_addr` holds its value.
- R8: A `commit` with no loaded byte, or with `wr_protect` latched high, closes the transaction without raising `busy` and changes neither the array nor `next_addr`.
- R9: While `busy` is high, `txn_start`, `byte_stb` and `commit` are ignored.
- R10: `byte_stb` and `commit` are ignored when no transaction is open.
- R11: `rd_data` shows the array byte at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a write transaction |
| txn_addr | input | ADDR_W | Start byte address, sampled with txn_start |
| wr_protect | input | 1 | Write protect, sampled with txn_start |
| byte_stb | input | 1 | Data byte valid |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | End of transfer, write request |
| busy | output | 1 | Timed write cycle in progress |
| next_addr | output | ADDR_W | Address one past the last byte written |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
A wrong pointer or row register puts bytes at the wrong place or spills them into a neighbouring row. The row readback after each commit shows this as soon as `busy` falls. A stale loaded-byte mask writes bytes from an earlier transaction, so locations that should keep their old value change. A fault in the timer or the state machine makes the `busy` pulse the wrong length, or makes it appear after an empty or protected commit. The bench sees this within TW_CYCLES+1 cycles of the commit, and `next_addr` exposes a wrong last offset at the same edge.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_WRITE = 2'd2
    } eepc_state_e;

    typedef struct packed {
        logic clr;
        logic we;
        logic mem_we;
    } eepc_ctl_t;
endpackage

// File: rtl/eepc_page_latch.sv
module eepc_page_latch
    import eepc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  byte_t                 din,
    output logic [ROW_W-1:0]      row,
    output logic [OFS_W-1:0]      ptr,
    output logic [OFS_W-1:0]      last,
    output logic [PAGE_BYTES-1:0] mask,
    output byte_t                 page [PAGE_BYTES]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row  <= '0;
            ptr  <= '0;
            last <= '0;
            mask <= '0;
        end else if (clr) begin
            row  <= addr[ADDR_W-1:OFS_W];
            ptr  <= addr[OFS_W-1:0];
            mask <= '0;
        end else if (we) begin
            mask[ptr] <= 1'b1;
            last      <= ptr;
            ptr       <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !clr) begin
            page[ptr] <= din;
        end
    end
endmodule

// File: rtl/eepc_ctrl.sv
module eepc_ctrl
    import eepc_pkg::*;
#(
    parameter int TW_CYCLES = 12,
    localparam int CNT_W    = $clog2(TW_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        txn_start,
    input  logic        byte_stb,
    input  logic        commit,
    input  logic        wr_protect,
    input  logic        has_bytes,
    output eepc_state_e state,
    output logic        wp_q,
    output eepc_ctl_t   ctl
);
    logic [CNT_W-1:0] cnt;
    logic             start_ok;
    logic             go;

    assign start_ok   = txn_start && (state != ST_WRITE);
    assign go         = commit && (state == ST_LOAD) && !txn_start;
    assign ctl.clr    = start_ok;
    assign ctl.we     = byte_stb && (state == ST_LOAD) && !txn_start;
    assign ctl.mem_we = (state == ST_WRITE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wp_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_LOAD: begin
                    if (start_ok) begin
                        state <= ST_LOAD;
                        wp_q  <= wr_protect;
                    end else if (go) begin
                        if (has_bytes && !wp_q) begin
                            state <= ST_WRITE;
                            cnt   <= CNT_W'(TW_CYCLES - 1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eepc_array.sv
module eepc_array
    import eepc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFS_W,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ROW_W-1:0]      row,
    input  logic [PAGE_BYTES-1:0] mask,
    input  byte_t                 page [PAGE_BYTES],
    input  logic [ADDR_W-1:0]     rd_addr,
    output byte_t                 rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (we) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem[{row, OFS_W'(i)}] <= page[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
    import eepc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int TW_CYCLES  = 12,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              wr_protect,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              commit,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    eepc_state_e           ctrl_state;
    eepc_ctl_t             ctl;
    logic                  wp_q;
    logic [ROW_W-1:0]      lat_row;
    logic [OFS_W-1:0]      lat_ptr;
    logic [OFS_W-1:0]      lat_last;
    logic [PAGE_BYTES-1:0] lat_mask;
    byte_t                 lat_page [PAGE_BYTES];

    eepc_ctrl #(.TW_CYCLES(TW_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start),
        .byte_stb  (byte_stb),
        .commit    (commit),
        .wr_protect(wr_protect),
        .has_bytes (|lat_mask),
        .state     (ctrl_state),
        .wp_q      (wp_q),
        .ctl       (ctl)
    );

    eepc_page_latch #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_latch (
        .clk (clk),
        .rst (rst),
        .clr (ctl.clr),
        .we  (ctl.we),
        .addr(txn_addr),
        .din (byte_data),
        .row (lat_row),
        .ptr (lat_ptr),
        .last(lat_last),
        .mask(lat_mask),
        .page(lat_page)
    );

    eepc_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (ctl.mem_we),
        .row    (lat_row),
        .mask   (lat_mask),
        .page   (lat_page),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)             next_addr <= '0;
        else if (ctl.mem_we) next_addr <= {lat_row, lat_last} + 1'b1;
    end

    assign busy = (ctrl_state == ST_WRITE);
endmodule

// File: rtl/eepc_checker.sv
module eepc_checker
    import eepc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int TW_CYCLES  = 12,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int ROW_W     = ADDR_W - OFS_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic [ADDR_W-1:0]     next_addr,
    input logic                  txn_start,
    input logic                  byte_stb,
    input logic                  commit,
    input eepc_state_e           st,
    input logic [OFS_W-1:0]      ptr,
    input logic [ROW_W-1:0]      row,
    input logic [PAGE_BYTES-1:0] mask,
    input logic                  wp_q
);
    logic [15:0] blen;

    always_ff @(posedge clk) begin
        if (rst || !busy) blen <= '0;
        else              blen <= blen + 1'b1;
    end

    AST_BUSY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (commit && st == ST_LOAD && !txn_start && (mask != '0) && !wp_q) |=> busy); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen == 16'(TW_CYCLES))); // R5
    AST_NULL_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (commit && st == ST_LOAD && !txn_start && ((mask == '0) || wp_q)) |=> !busy); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(next_addr)); // R7
    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (txn_start && !busy) |=> (mask == '0)); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && st == ST_LOAD && !txn_start) |=> (ptr == OFS_W'($past(ptr) + 1'b1))); // R4
    AST_ROW_FIXED: assert property (@(posedge clk) disable iff (rst)
        !txn_start |=> $stable(row)); // R4
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (busy && txn_start) |=> $stable(row)); // R9
endmodule

bind eeprom_page_commit eepc_checker #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .TW_CYCLES(TW_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .next_addr(next_addr),
    .txn_start(txn_start), .byte_stb(byte_stb), .commit(commit),
    .st(ctrl_state), .ptr(lat_ptr), .row(lat_row), .mask(lat_mask), .wp_q(wp_q)
);

// File: tb/sim_eeprom_page_commit.sv
module sim_eeprom_page_commit;
    localparam int ADDR_W = 10;
    localparam int PB     = 32;
    localparam int TW     = 12;
    localparam int OFS_W  = $clog2(PB);
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              txn_start = 1'b0;
    logic [ADDR_W-1:0] txn_addr = '0;
    logic              wr_protect = 1'b0;
    logic              byte_stb = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              commit = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0]        ref_mem [DEPTH];
    logic [ADDR_W-1:0] ref_next;

    always #10 clk = ~clk;

    eeprom_page_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .TW_CYCLES(TW)) u0 (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_addr(txn_addr),
        .wr_protect(wr_protect), .byte_stb(byte_stb), .byte_data(byte_data),
        .commit(commit), .busy(busy), .next_addr(next_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int row_base(input int addr);
        return (addr / PB) * PB;
    endfunction

    task automatic check_range(input int base, input int len, input string req);
        int bad = -1;
        int act = 0;
        int exp = 0;
        for (int a = base; a < base + len; a++) begin
            rd_addr = ADDR_W'(a);
            #0.1;
            if (bad < 0 && rd_data !== ref_mem[a]) begin
                bad = a; act = int'(rd_data); exp = int'(ref_mem[a]);
            end
        end
        check(bad < 0, req, act, exp);
    endtask

    // Open a transaction, send n bytes, optionally commit; the model follows the requirements
    task automatic run_txn(input int addr, input bit wp, input int n, input bit do_commit);
        int ptr = addr % PB;
        int base = row_base(addr);
        int last = -1;
        logic [7:0] pg [PB];
        bit         pm [PB];
        int cnt;
        for (int i = 0; i < PB; i++) pm[i] = 1'b0;
        @(negedge clk);
        txn_start = 1'b1; txn_addr = ADDR_W'(addr); wr_protect = wp;
        @(negedge clk);
        txn_start = 1'b0; wr_protect = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1; byte_data = 8'($urandom);
            pg[ptr] = byte_data; pm[ptr] = 1'b1; last = ptr;
            ptr = (ptr + 1) % PB;             // R4 wrap inside the row
            @(negedge clk);
        end
        byte_stb = 1'b0;
        if (!do_commit) return;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        if (n > 0 && !wp) begin
            check(busy === 1'b1, "R5 busy after commit", int'(busy), 1);
            cnt = 1;
            while (cnt < 1000) begin
                @(negedge clk);
                if (!busy) break;
                cnt++;
            end
            check(cnt == TW, "R5 busy length", cnt, TW);
            for (int i = 0; i < PB; i++) if (pm[i]) ref_mem[base + i] = pg[i];
            ref_next = ADDR_W'(base + last + 1);
            check(next_addr === ref_next, "R7 next_addr", int'(next_addr), int'(ref_next));
            check_range(base, PB, "R6 row contents");
        end else begin
            check(busy === 1'b0, "R8 no busy on null commit", int'(busy), 0);
            check(next_addr === ref_next, "R8 next_addr held", int'(next_addr), int'(ref_next));
            check_range(base, PB, "R8 row unchanged");
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'h00;
        ref_next = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy reset", int'(busy), 0);
        check(next_addr === '0, "R1 next_addr reset", int'(next_addr), 0);
        check_range(0, DEPTH, "R1 array cleared, R11 read port");

        // R10 strays without an open transaction
        byte_stb = 1'b1; byte_data = 8'hA5; @(negedge clk);
        byte_stb = 1'b0; commit = 1'b1; @(negedge clk);
        commit = 1'b0; @(negedge clk);
        check(busy === 1'b0, "R10 stray commit", int'(busy), 0);
        check_range(0, PB, "R10 stray byte not stored");

        // R3 single byte write; R5/R6/R7 checked inside
        run_txn(37, 1'b0, 1, 1'b1);
        // R3 full page from offset 0
        run_txn(64, 1'b0, PB, 1'b1);
        // R4 wrap: start at offset PB-2, overrun row by several bytes
        run_txn(3 * PB + PB - 2, 1'b0, PB + 5, 1'b1);
        // R8 protected commit and empty commit
        run_txn(5 * PB + 3, 1'b1, 4, 1'b1);
        run_txn(6 * PB + 1, 1'b0, 0, 1'b1);
        // R7 counter wraps at top of address space
        run_txn(DEPTH - 1, 1'b0, 1, 1'b1);
        check(next_addr === '0, "R7 next_addr modulo", int'(next_addr), 0);

        // R2 restart: first transaction abandoned, only the second is written
        run_txn(8 * PB + 4, 1'b0, 3, 1'b0);
        run_txn(9 * PB + 7, 1'b0, 2, 1'b1);
        check_range(8 * PB, PB, "R2 abandoned bytes not written");

        // R9 requests during busy are ignored
        @(negedge clk);
        txn_start = 1'b1; txn_addr = ADDR_W'(10 * PB); @(negedge clk);
        txn_start = 1'b0; byte_stb = 1'b1; byte_data = 8'h3C;
        ref_mem[10 * PB] = 8'h3C; @(negedge clk);
        byte_stb = 1'b0; commit = 1'b1; @(negedge clk);
        commit = 1'b0;
        txn_start = 1'b1; txn_addr = ADDR_W'(11 * PB); @(negedge clk);
        txn_start = 1'b0; byte_stb = 1'b1; byte_data = 8'hFF; @(negedge clk);
        byte_stb = 1'b0; commit = 1'b1; @(negedge clk);
        commit = 1'b0;
        while (busy) @(negedge clk);
        ref_next = ADDR_W'(10 * PB + 1);
        commit = 1'b1; byte_stb = 1'b1; @(negedge clk);
        commit = 1'b0; byte_stb = 1'b0; @(negedge clk);
        check(busy === 1'b0, "R9 start during busy ignored", int'(busy), 0);
        check(next_addr === ref_next, "R9 next_addr", int'(next_addr), int'(ref_next));
        check_range(10 * PB, 2 * PB, "R9 array after busy");

        // Random transactions
        for (int k = 0; k < 40; k++) begin
            int addr = int'($urandom % DEPTH);
            int n    = int'($urandom % (PB + 8));
            bit wp   = ($urandom % 5) == 0;
            run_txn(addr, wp, n, 1'b1);
        end
        check_range(0, DEPTH, "R6 final array, R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule